// File: doc/BRIEF.md
# Paired Interval Timer with Buffered Compare

This block holds two 8-bit up-counting timer channels behind a small register bus. Each channel has a software-written data register and a separate compare latch. A channel counts only on cycles where its count-enable strobe is high. That strobe can come from an internal prescaled clock (interval timing) or from a synchronised external event (event counting). When the count equals the compare latch on a strobe, the channel does three things: it returns to zero, it copies the data register into the latch, and it pulses its match output. A write to the data register during a running period therefore applies only from the next period onward.

A bus read at a channel's data address returns the live count. The value last written there cannot be read back. A sticky match flag can be cleared by software and is gated by an interrupt-enable bit to drive the interrupt output. Setting a mode bit in channel 0's control register joins the two channels into one 16-bit timer. Channel 0's data register gives bits 7:0 of the compare value and channel 1's gives bits 15:8. Channel 0's strobe and control bits then drive both bytes.

Top module: `ivl_timer_pair`

## Requirements
- R1: A read at a data address (1 for channel 0, 3 for channel 1) returns that channel's current count, never the value written there.
- R2: A control write (address 0 or 2) with start bit 0 set, when the stored start bit is 0 and stop bit 1 of the written value is 0, starts the channel. The count becomes 0 and the latch takes the data register. After that each strobe adds 1.
- R3: On a strobe with count equal to the latch, the count becomes 0, the latch is reloaded and the match output is high for the next cycle. A data value D gives a period of D+1 strobes.
- R4: A data write during a period does not change that period's length. It sets the length of the period that follows the next match.
- R5: Cycles without a strobe leave the count unchanged. One channel's strobe does not move the other channel in 8-bit mode.
- R6: Every match sets the flag (control bit 3). The flag stays set until a control write with bit 3 at 0, and a control write with bit 3 at 1 leaves it unchanged.
- R7: The interrupt output equals the flag ANDed with interrupt-enable (control bit 2).
- R8: A control write with stop bit 1 set halts the channel. Strobes then leave the count frozen, and the next start edge restarts counting from 0.
- R9: With control bit 4 of channel 0 set, the count is {count1,count0} and the compare value is {data1,data0}. Channel 0's strobe and start drive both bytes. A match needs both bytes equal at once, both bytes clear together, and it appears only on match output 0.
- R10: After reset the counts and control registers read 0, and the match and interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 ctrl0, 1 data0, 2 ctrl1, 3 data1 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: control bits or live count |
| cnt_tick | input | 2 | Per-channel count-enable strobe |
| match_o | output | 2 | One-cycle match pulse per channel |
| irq_o | output | 2 | Per-channel interrupt (flag AND enable) |

## Verification
Every data value from 0 to 255 is started on channel 0 and run a few strobes past its first wrap. This tells a period of D+1 apart from periods one too long or one too short, and it also exercises the 0 and 255 edge values. A mid-period data write tells a buffered latch apart from a direct compare against the data register. Stop-then-restart and strobe-free idle cycles tell a gated counter apart from a free-running one. A 16-bit run with compare 0x0105 passes the point where only the low byte matches, and it also passes a low-byte carry. This shows whether the joint match and the carry into the high byte work.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;
    localparam int NCH    = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL0 = 2'd0,
        A_DATA0 = 2'd1,
        A_CTRL1 = 2'd2,
        A_DATA1 = 2'd3
    } reg_addr_e;

    // Control register layout, bit 0 is start.
    typedef struct packed {
        logic wide;
        logic flag;
        logic irq_en;
        logic stop;
        logic start;
    } ctrl_bits_t;

    localparam int CTRL_W = $bits(ctrl_bits_t);

    function automatic logic addr_is_count(input logic [ADDR_W-1:0] a);
        return a[0];
    endfunction

    function automatic int unsigned addr_chan(input logic [ADDR_W-1:0] a);
        return int'(a[ADDR_W-1:1]);
    endfunction

endpackage

// File: rtl/tmr_chan_ctrl.sv
module tmr_chan_ctrl
    import tmr_pkg::*;
#(
    parameter bit HAS_WIDE = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_wr,
    input  ctrl_bits_t wr_bits,
    input  logic       hit,
    output logic       start_pulse,
    output logic       run,
    output ctrl_bits_t ctrl,
    output logic       match,
    output logic       irq
);

    ctrl_bits_t ctrl_q;
    logic       run_q;
    logic       match_q;
    logic       flag_clr;

    assign start_pulse = ctrl_wr && wr_bits.start && !ctrl_q.start && !wr_bits.stop;
    assign flag_clr    = ctrl_wr && !wr_bits.flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            run_q   <= 1'b0;
            match_q <= 1'b0;
        end else begin
            match_q <= hit;
            if (ctrl_wr) begin
                ctrl_q.start  <= wr_bits.start;
                ctrl_q.stop   <= wr_bits.stop;
                ctrl_q.irq_en <= wr_bits.irq_en;
                ctrl_q.wide   <= HAS_WIDE ? wr_bits.wide : 1'b0;
            end
            if (hit)
                ctrl_q.flag <= 1'b1;
            else if (flag_clr)
                ctrl_q.flag <= 1'b0;
            if (ctrl_wr && wr_bits.stop)
                run_q <= 1'b0;
            else if (start_pulse)
                run_q <= 1'b1;
        end
    end

    assign ctrl  = ctrl_q;
    assign run   = run_q;
    assign match = match_q;
    assign irq   = ctrl_q.flag && ctrl_q.irq_en;

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.flag && !flag_clr) |=> ctrl_q.flag);

    assert_hit_sets_flag_R6: assert property (@(posedge clk) disable iff (rst)
        hit |=> (ctrl_q.flag && match_q));

    assert_stop_halts_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wr_bits.stop) |=> !run_q);

endmodule

// File: rtl/tmr_count_byte.sv
module tmr_count_byte #(
    parameter int W = tmr_pkg::BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         data_wr,
    input  logic [W-1:0] data_in,
    input  logic         load,
    input  logic         wrap,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         eq
);

    logic [W-1:0] data_q;
    logic [W-1:0] latch_q;
    logic [W-1:0] cnt_q;

    // The data register has no reset; software must write it before a start.
    always_ff @(posedge clk) begin
        if (data_wr)
            data_q <= data_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            latch_q <= '0;
        end else if (load || wrap) begin
            cnt_q   <= '0;
            latch_q <= data_q;
        end else if (inc) begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;
    assign eq  = (cnt_q == latch_q);

    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!load && !wrap) |=> $stable(latch_q));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (inc && !load && !wrap) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/ivl_timer_pair.sv
module ivl_timer_pair
    import tmr_pkg::*;
#(
    parameter int W = tmr_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [NCH-1:0]    cnt_tick,
    output logic [NCH-1:0]    match_o,
    output logic [NCH-1:0]    irq_o
);

    localparam int PAD_W = W - CTRL_W;

    logic [NCH-1:0] start_p;
    logic [NCH-1:0] run;
    logic [NCH-1:0] eq;
    logic [NCH-1:0] load;
    logic [NCH-1:0] wrap;
    logic [NCH-1:0] inc;
    logic [NCH-1:0] hit;
    logic [NCH-1:0] ctrl_wr;
    logic [NCH-1:0] data_wr;
    logic [W-1:0]   cnt    [NCH];
    ctrl_bits_t     ctrl_q [NCH];
    ctrl_bits_t     wr_bits;

    logic wide;
    logic adv_lo, adv_hi, hit_lo, hit_hi;

    assign wr_bits = ctrl_bits_t'(bus_wdata[CTRL_W-1:0]);

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_chan
            assign ctrl_wr[i] = bus_wr && (bus_addr == ADDR_W'(2 * i));
            assign data_wr[i] = bus_wr && (bus_addr == ADDR_W'(2 * i + 1));

            tmr_chan_ctrl #(
                .HAS_WIDE (i == 0)
            ) u_ctrl (
                .clk         (clk),
                .rst         (rst),
                .ctrl_wr     (ctrl_wr[i]),
                .wr_bits     (wr_bits),
                .hit         (hit[i]),
                .start_pulse (start_p[i]),
                .run         (run[i]),
                .ctrl        (ctrl_q[i]),
                .match       (match_o[i]),
                .irq         (irq_o[i])
            );

            tmr_count_byte #(
                .W (W)
            ) u_byte (
                .clk     (clk),
                .rst     (rst),
                .data_wr (data_wr[i]),
                .data_in (bus_wdata),
                .load    (load[i]),
                .wrap    (wrap[i]),
                .inc     (inc[i]),
                .cnt     (cnt[i]),
                .eq      (eq[i])
            );
        end
    endgenerate

    // Channel glue: in wide mode channel 0 controls both bytes.
    always_comb begin
        wide   = ctrl_q[0].wide;
        adv_lo = run[0] && cnt_tick[0];
        adv_hi = wide ? adv_lo : (run[1] && cnt_tick[1]);
        hit_lo = adv_lo && eq[0] && (!wide || eq[1]);
        hit_hi = !wide && adv_hi && eq[1];
        hit    = {hit_hi, hit_lo};
        load   = {(wide ? start_p[0] : start_p[1]), start_p[0]};
        wrap   = {(wide ? hit_lo : hit_hi), hit_lo};
        inc    = {(wide ? (adv_lo && (&cnt[0])) : adv_hi), adv_lo};
    end

    always_comb begin
        if (addr_is_count(bus_addr))
            bus_rdata = cnt[addr_chan(bus_addr)];
        else
            bus_rdata = {{PAD_W{1'b0}}, ctrl_q[addr_chan(bus_addr)]};
    end

    assert_match_at_zero_R3: assert property (@(posedge clk) disable iff (rst)
        match_o[0] |-> (cnt[0] == '0));

    assert_idle_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (!cnt_tick[0] && !ctrl_wr[0]) |=> $stable(cnt[0]));

    assert_wide_hi_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (wide && $past(wide)) |-> !match_o[1]);

    assert_wide_joint_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (wide && match_o[0]) |-> (cnt[1] == '0));

endmodule

// File: tb/test_ivl_timer_pair.sv
module test_ivl_timer_pair;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    localparam logic [1:0] CTRL0 = 2'd0;
    localparam logic [1:0] DATA0 = 2'd1;
    localparam logic [1:0] CTRL1 = 2'd2;
    localparam logic [1:0] DATA1 = 2'd3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] cnt_tick = '0;
    logic [1:0] match_o;
    logic [1:0] irq_o;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;

    ivl_timer_pair i_ivl_timer_pair (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_tick  (cnt_tick),
        .match_o   (match_o),
        .irq_o     (irq_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic tick(input logic [1:0] m);
        cnt_tick = m;
        @(negedge clk);
        cnt_tick = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                fails++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [7:0] v, lo, hi;
        int exp_c;

        idle(3);
        @(negedge clk);
        rst = 1'b0;

        // R10: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R10 reset read", v, 0);
        end
        chk("R10 reset match", match_o, 0);
        chk("R10 reset irq", irq_o, 0);

        // R2 R3 R7: sweep every data value on channel 0
        for (int d = 0; d < 256; d++) begin
            wr(DATA0, 8'(d));
            wr(CTRL0, 8'h00);
            wr(CTRL0, 8'h05);
            rd(DATA0, v);
            chk("R2 start clears count", v, 0);
            for (int k = 1; k <= d + 3; k++) begin
                tick(2'b01);
                rd(DATA0, v);
                chk("R3 count value", v, k % (d + 1));
                chk("R3 match pulse", match_o[0], (k % (d + 1)) == 0);
                chk("R7 irq follows flag", irq_o[0], k >= d + 1);
            end
        end

        // R6: flag sticky, write 1 keeps it, write 0 clears; count untouched
        rd(CTRL0, v);
        chk("R6 flag set", v[3], 1);
        wr(CTRL0, 8'h0D);
        rd(CTRL0, v);
        chk("R6 flag kept on write 1", v[3], 1);
        rd(DATA0, lo);
        wr(CTRL0, 8'h05);
        rd(CTRL0, v);
        chk("R6 flag cleared", v[3], 0);
        chk("R7 irq low after clear", irq_o[0], 0);
        rd(DATA0, v);
        chk("R6 count not restarted", v, lo);

        // R7: flag set with enable off gives no interrupt
        wr(DATA0, 8'd1);
        wr(CTRL0, 8'h00);
        wr(CTRL0, 8'h01);
        tick(2'b01); tick(2'b01);
        rd(CTRL0, v);
        chk("R7 flag set", v[3], 1);
        chk("R7 irq gated off", irq_o[0], 0);

        // R1 R4: mid-period data write
        wr(DATA0, 8'd3);
        wr(CTRL0, 8'h00);
        wr(CTRL0, 8'h01);
        tick(2'b01);
        wr(DATA0, 8'hAB);
        rd(DATA0, v);
        chk("R1 read returns count", v, 1);
        wr(DATA0, 8'd6);
        for (int k = 2; k <= 4; k++) begin
            tick(2'b01);
            rd(DATA0, v);
            chk("R4 old period count", v, k % 4);
            chk("R4 old period match", match_o[0], k == 4);
        end
        for (int k = 1; k <= 7; k++) begin
            tick(2'b01);
            rd(DATA0, v);
            chk("R4 new period count", v, k % 7);
            chk("R4 new period match", match_o[0], k == 7);
        end

        // R5: no strobe, and other channel strobe, leave count alone
        tick(2'b01); tick(2'b01);
        idle(5);
        rd(DATA0, v);
        chk("R5 idle hold", v, 2);
        tick(2'b10);
        rd(DATA0, v);
        chk("R5 other strobe", v, 2);

        // R8: stop freezes, restart from zero
        wr(CTRL0, 8'h03);
        tick(2'b01); tick(2'b01); tick(2'b01);
        rd(DATA0, v);
        chk("R8 frozen", v, 2);
        wr(CTRL0, 8'h00);
        wr(CTRL0, 8'h01);
        rd(DATA0, v);
        chk("R8 restart zero", v, 0);
        tick(2'b01);
        rd(DATA0, v);
        chk("R8 counts again", v, 1);

        // R3 R5: channel 1 in 8-bit mode, channel 0 idle
        wr(CTRL0, 8'h02);
        for (int d = 0; d < 6; d++) begin
            wr(DATA1, 8'(d));
            wr(CTRL1, 8'h00);
            wr(CTRL1, 8'h05);
            for (int k = 1; k <= d + 2; k++) begin
                tick(2'b10);
                rd(DATA1, v);
                chk("R3 ch1 count", v, k % (d + 1));
                chk("R3 ch1 match", match_o[1], (k % (d + 1)) == 0);
                chk("R7 ch1 irq", irq_o[1], k >= d + 1);
            end
            rd(DATA0, v);
            chk("R5 ch0 unmoved", v, 1);
        end
        wr(CTRL1, 8'h02);

        // R9: 16-bit mode, compare 0x0105
        wr(DATA0, 8'h05);
        wr(DATA1, 8'h01);
        wr(CTRL0, 8'h10);
        wr(CTRL0, 8'h11);
        for (int k = 1; k <= 264; k++) begin
            tick(2'b01);
            rd(DATA0, lo);
            rd(DATA1, hi);
            exp_c = k % 262;
            chk("R9 wide count", {hi, lo}, exp_c);
            chk("R9 wide match", match_o[0], exp_c == 0);
            chk("R9 high match quiet", match_o[1], 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule